// File: doc/BRIEF.md
# Pipelined Converter Digital Error Correction

This block sits behind the analog stages of a pipelined analog-to-digital converter. On every clock it receives a 2-bit decision from each of eight redundant 1.5-bit stages and one bit from a closing comparator. Stage i works on a given sample i clocks after stage 0 does. Stage 0 is the coarsest stage. A sample is therefore spread over nine consecutive cycles when it arrives. The block gives each stage a delay line whose length undoes that skew. The nine decisions for one sample then meet in the same cycle. There they are added with a one-bit overlap between neighbours, which cancels the stage redundancy and yields one 10-bit word per sample.

A valid strobe enters with the stage-0 decision of each sample and travels alongside the data. Decision value 3 is not a legal 1.5-bit result. It is summed as 2 and latches an error flag until the next reset.

Top module: `pipe_adc_corrector`

## Requirements
- R1: Reset is synchronous and active low. While it is held, out_valid, out_code and code_err are 0. Every delay line is cleared, so after release no out_valid appears until a new sample has travelled through.
- R2: Each in_valid sampled high gives exactly one out_valid pulse. The pulse is visible 8 rising edges after the edge that sampled in_valid (N_STAGES in general). Back-to-back samples are accepted on every cycle.
- R3: stage_code[2i+1:2i] carries stage i. For a sample accepted at edge E, stage i's code is taken at edge E+i and final_bit at edge E+8.
- R4: out_code is the unsigned sum of code_i·2^(8−i) over stages 0 to 7, plus final_bit. It is 10 bits wide, and its largest possible value is 1021.
- R5: While out_valid is low, out_code keeps its last value, which is 0 after reset.
- R6: A stage code of 3 is weighted exactly as a code of 2.
- R7: code_err becomes 1 on the edge after a 3 is sampled on stage i in a cycle where stage i holds a valid sample. It stays 1 until reset. A 3 on a slot that belongs to no valid sample does not set it.
- R8: The codes come from an ideal residue pipeline with input r0 in [−V, V). Each stage has thresholds ±V/4 and residue 2r − (c−1)·V, and final_bit = (last residue ≥ 0). For such codes, out_code lies within 2 codes of 512·r0/V + 510.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks the cycle in which stage 0 carries a new sample |
| stage_code | input | 2*N_STAGES | 1.5-bit decisions; bits [2i+1:2i] belong to stage i |
| final_bit | input | 1 | Decision of the closing comparator |
| out_valid | output | 1 | A corrected word is present on out_code |
| out_code | output | N_STAGES+2 | Corrected output word |
| code_err | output | 1 | Sticky flag: an illegal code 3 was seen for a valid sample |

## Verification
In steady streaming, up to nine different samples sit in different stages in one cycle. During that same cycle the output register loads the finished sum of the oldest sample. In that cycle the error flag can also be raised by an illegal code that belongs to a younger sample. The bench provokes this with back-to-back samples in which a 3 is planted at various stage positions. It also places 3s on idle slots between gapped samples. Every emerging word is matched against its own sample's expected sum and its own arrival edge. The flag is compared every cycle with a model that counts only the 3s that fall on valid slots.

// File: rtl/adc_corr_pkg.sv
// Shared types for the pipelined-converter correction logic.
// Assumes 1.5-bit stage decisions coded as 0, 1, 2; value 3 is illegal.
package adc_corr_pkg;
    localparam int unsigned CODE_W = 2;
    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_HI  = 2'd2;
    localparam code_t CODE_BAD = 2'd3;

    // Map the illegal decision onto the nearest legal one.
    function automatic code_t fold_code(input code_t c);
        return (c == CODE_BAD) ? CODE_HI : c;
    endfunction
endpackage

// File: rtl/adc_stage_delay.sv
// Fixed-length shift register that delays one stage decision.
// Assumes DEPTH >= 1; all taps clear on reset.
module adc_stage_delay #(
    parameter int unsigned WIDTH = 2,
    parameter int unsigned DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] taps [DEPTH];

    // Shift the decision one tap per clock, clearing every tap on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) taps[k] <= '0;
        end else begin
            taps[0] <= d;
            for (int k = 1; k < DEPTH; k++) taps[k] <= taps[k-1];
        end
    end

    assign q = taps[DEPTH-1];
endmodule

// File: rtl/adc_code_guard.sv
// Folds illegal decisions (3 -> 2) and keeps a sticky error flag.
// Assumes slot_live[i] is high when stage i currently holds a valid sample.
module adc_code_guard
    import adc_corr_pkg::*;
#(
    parameter int unsigned N_STAGES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_STAGES*CODE_W-1:0] raw_codes,
    input  logic [N_STAGES-1:0]        slot_live,
    output logic [N_STAGES*CODE_W-1:0] clean_codes,
    output logic                       err_flag
);
    logic [N_STAGES-1:0] bad;

    for (genvar i = 0; i < N_STAGES; i++) begin : g_fold
        assign clean_codes[i*CODE_W +: CODE_W] = fold_code(raw_codes[i*CODE_W +: CODE_W]);
        assign bad[i] = slot_live[i] && (raw_codes[i*CODE_W +: CODE_W] == CODE_BAD);
    end

    // Latch any illegal decision on a live slot until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   err_flag <= 1'b0;
        else if (|bad) err_flag <= 1'b1;
    end

    // R7: once raised, the flag never drops without reset.
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
endmodule

// File: rtl/adc_overlap_sum.sv
// Weighted overlap add of aligned decisions: sum of c_i * 2^(N-i) + final bit.
// Assumes the decisions were already folded to the legal range 0..2.
module adc_overlap_sum
    import adc_corr_pkg::*;
#(
    parameter int unsigned N_STAGES = 8,
    localparam int unsigned SUM_W   = N_STAGES + 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_STAGES*CODE_W-1:0] aligned_codes,
    input  logic                       last_bit,
    output logic [SUM_W-1:0]           total
);
    // Accumulate each stage shifted so neighbours overlap by one bit.
    always_comb begin
        total = SUM_W'(last_bit);
        for (int i = 0; i < N_STAGES; i++) begin
            total = total + (SUM_W'(aligned_codes[i*CODE_W +: CODE_W]) << (N_STAGES - i));
        end
    end

    for (genvar i = 0; i < N_STAGES; i++) begin : g_chk
        // R6: the delay lines deliver only folded decisions to the adder.
        p_clean_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
            aligned_codes[i*CODE_W +: CODE_W] != CODE_BAD);
    end
endmodule

// File: rtl/pipe_adc_corrector.sv
// Top: aligns per-stage decisions of one sample and emits the corrected word.
// Assumes in_valid accompanies the stage-0 decision; N_STAGES >= 2.
module pipe_adc_corrector
    import adc_corr_pkg::*;
#(
    parameter int unsigned N_STAGES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [N_STAGES*CODE_W-1:0] stage_code,
    input  logic                       final_bit,
    output logic                       out_valid,
    output logic [N_STAGES+1:0]        out_code,
    output logic                       code_err
);
    localparam int unsigned SUM_W = N_STAGES + 2;
    localparam int unsigned LAT   = N_STAGES;
    localparam int unsigned CNT_W = $clog2(LAT + 2);
    localparam logic [SUM_W-1:0] MAX_SUM = SUM_W'((2 ** SUM_W) - 3);

    logic [N_STAGES-1:0]        vpipe;
    logic [N_STAGES-1:0]        slot_live;
    logic [N_STAGES*CODE_W-1:0] clean_codes;
    logic [N_STAGES*CODE_W-1:0] aligned_codes;
    logic [SUM_W-1:0]           total;
    logic [CNT_W-1:0]           since_rst;

    // Carry the valid strobe along with the sample through the stage skew.
    always_ff @(posedge clk) begin
        if (!rst_n) vpipe <= '0;
        else        vpipe <= {vpipe[N_STAGES-2:0], in_valid};
    end

    assign slot_live[0] = in_valid;
    for (genvar i = 1; i < N_STAGES; i++) begin : g_live
        assign slot_live[i] = vpipe[i-1];
    end

    adc_code_guard #(.N_STAGES(N_STAGES)) u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .raw_codes   (stage_code),
        .slot_live   (slot_live),
        .clean_codes (clean_codes),
        .err_flag    (code_err)
    );

    for (genvar i = 0; i < N_STAGES; i++) begin : g_align
        adc_stage_delay #(.WIDTH(CODE_W), .DEPTH(N_STAGES - i)) u_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (clean_codes[i*CODE_W +: CODE_W]),
            .q     (aligned_codes[i*CODE_W +: CODE_W])
        );
    end

    adc_overlap_sum #(.N_STAGES(N_STAGES)) u_sum (
        .clk           (clk),
        .rst_n         (rst_n),
        .aligned_codes (aligned_codes),
        .last_bit      (final_bit),
        .total         (total)
    );

    // Register the corrected word when an aligned sample is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else begin
            out_valid <= vpipe[N_STAGES-1];
            if (vpipe[N_STAGES-1]) out_code <= total;
        end
    end

    // Count cycles since reset release, saturating, for the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n)                        since_rst <= '0;
        else if (since_rst <= CNT_W'(LAT)) since_rst <= since_rst + 1'b1;
    end

    // R1: first cycle out of reset shows cleared outputs.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && out_code == '0 && !code_err));
    // R2: no word can emerge before a sample has crossed the whole skew.
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (since_rst > CNT_W'(LAT)));
    // R4: the corrected word never exceeds the largest reachable sum.
    p_sum_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_code <= MAX_SUM));
    // R5: the word holds while no new sample is reported.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_code));
endmodule

// File: tb/tb_pipe_adc_corrector.sv
module tb_pipe_adc_corrector;
    localparam int NS   = 8;
    localparam int OW   = NS + 2;
    localparam int MAXS = 256;
    localparam int MAXQ = 512;

    // Table: {stage codes (stage i at bits 2i+1:2i), final bit, expected word}
    localparam int NVEC = 9;
    localparam logic [26:0] VEC [NVEC] = '{
        {16'h0000, 1'b0, 10'd0},
        {16'h0000, 1'b1, 10'd1},
        {16'hAAAA, 1'b1, 10'd1021},
        {16'h5555, 1'b0, 10'd510},
        {16'h5555, 1'b1, 10'd511},
        {16'h0002, 1'b0, 10'd512},
        {16'h0001, 1'b0, 10'd256},
        {16'h8000, 1'b1, 10'd5},
        {16'h9249, 1'b1, 10'd585}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [2*NS-1:0] stage_code = '0;
    logic final_bit = 1'b0;
    logic out_valid;
    logic [OW-1:0] out_code;
    logic code_err;

    pipe_adc_corrector #(.N_STAGES(NS)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .stage_code(stage_code),
        .final_bit(final_bit), .out_valid(out_valid), .out_code(out_code), .code_err(code_err)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0;
    bit done = 0, mon_en = 0;

    logic [15:0] sc [MAXS];
    logic        sf [MAXS];
    logic        sv [MAXS];
    int          sr [MAXS];
    logic        sk [MAXS];

    int   eq [MAXQ];
    int   iq [MAXQ];
    int   rq [MAXQ];
    logic kq [MAXQ];
    int   wr = 0, rd = 0;

    logic pend_bad = 1'b0;
    logic exp_err  = 1'b0;
    logic [OW-1:0] last_out = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R4/R6 weighting: code 3 counts as 2, stage i weighs 2^(8-i).
    function automatic int formula(input logic [15:0] c, input logic fb);
        int s;
        logic [1:0] v;
        s = int'(fb);
        for (int i = 0; i < NS; i++) begin
            v = c[2*i +: 2];
            if (v == 2'd3) v = 2'd2;
            s += int'(v) << (NS - i);
        end
        return s;
    endfunction

    // Ideal residue pipeline, V = 4096, thresholds +-V/4.
    task automatic resid(input int r0, output logic [15:0] c, output logic fb);
        int r, d;
        r = r0;
        c = '0;
        for (int i = 0; i < NS; i++) begin
            if (r > 1024) d = 2; else if (r < -1024) d = 0; else d = 1;
            c[2*i +: 2] = 2'(d);
            r = 2 * r - (d - 1) * 4096;
        end
        fb = (r >= 0);
    endtask

    // Model of the sticky error flag (R7).
    always @(posedge clk) begin
        if (!rst_n)        exp_err <= 1'b0;
        else if (pend_bad) exp_err <= 1'b1;
    end

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (mon_en) begin
            chk(code_err === exp_err, "R7 error flag", int'(code_err), int'(exp_err));
            if (out_valid) begin
                if (rd >= wr) begin
                    chk(1'b0, "R2 unexpected out_valid", 1, 0);
                end else begin
                    chk(int'(out_code) == eq[rd], "R3 R4 corrected word", int'(out_code), eq[rd]);
                    chk(cyc == iq[rd] + NS, "R2 latency", cyc, iq[rd] + NS);
                    if (kq[rd]) begin
                        int diff;
                        diff = 8 * int'(out_code) - 4080 - rq[rd];
                        chk(diff >= -16 && diff <= 16, "R8 ideal transfer", 8 * int'(out_code) - 4080, rq[rd]);
                    end
                    rd++;
                end
                last_out = out_code;
            end else begin
                chk(out_code === last_out, "R5 hold", int'(out_code), int'(last_out));
            end
        end
    end

    // Present samples staggered per stage (R3); idle slots carry code 3.
    task automatic drive_set(input int nsamp);
        logic bad;
        int j;
        for (int t = 0; t < nsamp + NS + 3; t++) begin
            @(negedge clk);
            bad = 1'b0;
            in_valid = (t < nsamp) && sv[t];
            if (in_valid) begin
                eq[wr] = formula(sc[t], sf[t]);
                iq[wr] = cyc + 1;
                rq[wr] = sr[t];
                kq[wr] = sk[t];
                wr++;
            end
            for (int i = 0; i < NS; i++) begin
                j = t - i;
                if (j >= 0 && j < nsamp) begin
                    stage_code[2*i +: 2] = sc[j][2*i +: 2];
                    if (sv[j] && sc[j][2*i +: 2] == 2'b11) bad = 1'b1;
                end else begin
                    stage_code[2*i +: 2] = 2'b11;
                end
            end
            j = t - NS;
            final_bit = (j >= 0 && j < nsamp) ? sf[j] : 1'b1;
            pend_bad = bad;
        end
        pend_bad = 1'b0;
        chk(rd == wr, "R2 one word per sample", rd, wr);
    endtask

    initial begin
        int n;
        logic [15:0] c;
        logic fb;

        // Reset state (R1)
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        chk(out_code === '0, "R1 reset out_code", int'(out_code), 0);
        chk(code_err === 1'b0, "R1 reset code_err", int'(code_err), 0);
        rst_n = 1'b1;
        mon_en = 1'b1;

        // Table walked back-to-back (R3, R4)
        for (int k = 0; k < NVEC; k++) begin
            sc[k] = VEC[k][26:11]; sf[k] = VEC[k][10]; sv[k] = 1'b1; sk[k] = 1'b0; sr[k] = 0;
            chk(formula(sc[k], sf[k]) == int'(VEC[k][9:0]), "R4 table entry", formula(sc[k], sf[k]), int'(VEC[k][9:0]));
        end
        drive_set(NVEC);

        // Same table with idle gaps carrying illegal codes (R5, R7)
        n = 0;
        for (int k = 0; k < NVEC; k++) begin
            sc[n] = VEC[k][26:11]; sf[n] = VEC[k][10]; sv[n] = 1'b1; sk[n] = 1'b0; n++;
            sc[n] = 16'hFFFF; sf[n] = 1'b1; sv[n] = 1'b0; sk[n] = 1'b0; n++;
        end
        drive_set(n);
        chk(code_err === 1'b0, "R7 idle-slot 3s ignored", int'(code_err), 0);

        // Ideal residue pipeline: edges and a sweep (R8)
        n = 0;
        foreach (VEC[k]) begin end
        begin
            int sp [9] = '{-4096, -1025, -1024, -1023, 0, 1, 1024, 1025, 4095};
            for (int k = 0; k < 9; k++) begin
                resid(sp[k], c, fb);
                sc[n] = c; sf[n] = fb; sv[n] = 1'b1; sr[n] = sp[k]; sk[n] = 1'b1; n++;
            end
        end
        for (int r = -4096; r < 4096; r += 67) begin
            resid(r, c, fb);
            sc[n] = c; sf[n] = fb; sv[n] = 1'b1; sr[n] = r; sk[n] = 1'b1; n++;
        end
        drive_set(n);

        // Illegal codes on valid samples (R6, R7)
        chk(code_err === 1'b0, "R7 flag clear before illegal codes", int'(code_err), 0);
        sc[0] = 16'h5555; sf[0] = 1'b1; sv[0] = 1'b1; sk[0] = 1'b0;
        sc[1] = 16'h55D5; sf[1] = 1'b1; sv[1] = 1'b1; sk[1] = 1'b0;
        sc[2] = 16'hFFFF; sf[2] = 1'b1; sv[2] = 1'b1; sk[2] = 1'b0;
        sc[3] = 16'hC000; sf[3] = 1'b0; sv[3] = 1'b1; sk[3] = 1'b0;
        chk(formula(16'h55D5, 1'b1) == 543, "R6 stage-3 fold", formula(16'h55D5, 1'b1), 543);
        chk(formula(16'hFFFF, 1'b1) == 1021, "R6 all-3 fold", formula(16'hFFFF, 1'b1), 1021);
        drive_set(4);
        chk(code_err === 1'b1, "R7 sticky after stream", int'(code_err), 1);

        // Reset in the middle of a stream (R1)
        mon_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_valid = 1'b1; stage_code = 16'h5555; final_bit = 1'b1;
        end
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(out_valid === 1'b0, "R1 mid-stream reset out_valid", int'(out_valid), 0);
        chk(out_code === '0, "R1 mid-stream reset out_code", int'(out_code), 0);
        chk(code_err === 1'b0, "R1 mid-stream reset code_err", int'(code_err), 0);
        rst_n = 1'b1;
        begin
            int seen;
            seen = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (out_valid !== 1'b0) seen++;
            end
            chk(seen == 0, "R1 no stale word after reset", seen, 0);
        end
        chk(out_code === '0, "R5 word stays 0 after reset", int'(out_code), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule